// File: doc/BRIEF.md
# Processor Run-Control Co-Processor

This block sits between a host command channel and a small multi-cycle 32-bit core. Each host command is one word-wide beat with a data value, a byte address and a target selector. Commands load and read back the instruction and data memories, set an argument register, copy that register into the program counter, start the core, stop it, and read two performance counters. Reads, and commands the block refuses, return a typed response one cycle later. Writes that the block accepts return no response.

While the core runs, the block watches each fetched word. When the dedicated halt word appears, the core is stopped and a level interrupt is raised. A second start mode runs the core for a cycle budget set by the host. That mode halts the core and raises the same interrupt when the budget is used up. A cycle counter and a retired-instruction counter give the host a cycles-per-instruction figure for each run.

Top module: `rc_run_coproc`

## Requirements
- R1: A command with target 0 (instruction memory) or 1 (data memory), sent while the core is idle to an in-range, word-aligned byte address, drives a memory write in the same cycle. The word index is the address divided by 4, and `hm_dmem` is 1 only for target 1. No response follows.
- R2: A command with target 3 (instruction memory) or 4 (data memory) drives a memory read in the same cycle. The next cycle carries a response of type 1 with the word that was read and the command's address.
- R3: A memory command whose address has either of its two low bits set, or lies at or above 4·2^AW, causes no memory access. It is answered with a response of type 0xE.
- R4: A target-2 command to address 1 stores its data in the argument register. A target-2 command to address 0 with data code 2 asserts `core_pc_load` in that cycle, and `core_pc_value` equals the argument register.
- R5: A target-2 command to address 0 with code 1 makes `core_run` high from the next cycle. After reset `core_run`, `irq` and `rsp_valid` are low.
- R6: While the core is running, a cycle with `core_fetch_valid` high and fetch word 0x40800000 drops `core_run` and raises `irq` at the next clock edge.
- R7: A target-2 command to address 2 sets the cycle budget. Code 3 then runs the core for exactly that many cycles, after which `core_run` drops and `irq` rises. Code 3 with a zero budget is answered with type 0xE and does not start the core.
- R8: Code 0 drops `core_run` at the next edge, at any time, and raises no interrupt.
- R9: The cycle counter counts every running cycle. The instruction counter counts `core_retire` pulses seen while the core runs. Codes 4 and 5 return the cycle and instruction counts in a type 2 response.
- R10: Both counters clear to zero on every start, in either mode.
- R11: `irq` stays high until the next valid host command. A halt event in the same cycle as a command still leaves `irq` high.
- R12: While the core runs, the following are refused with type 0xE and have no effect: memory writes and reads, argument and budget writes, PC load, and both start codes. Counter reads and stop remain allowed.
- R13: An unknown target (5 to 7), an unknown co-processor address, or an unknown command code is answered with type 0xE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command present this cycle |
| cmd_target | input | 3 | Target selector |
| cmd_addr | input | 32 | Byte address or co-processor register |
| cmd_data | input | 32 | Write data or command code |
| rsp_valid | output | 1 | Response present |
| rsp_type | output | 4 | 1 memory data, 2 counter, 0xE refused |
| rsp_addr | output | 32 | Address of the answered command |
| rsp_data | output | 32 | Response data |
| hm_en | output | 1 | Host memory access strobe |
| hm_we | output | 1 | Host memory write |
| hm_dmem | output | 1 | 1 data memory, 0 instruction memory |
| hm_word | output | AW | Word index |
| hm_wdata | output | 32 | Write data |
| hm_rdata | input | 32 | Read data, combinational from memory |
| core_run | output | 1 | Core enable |
| core_pc_load | output | 1 | Load PC strobe |
| core_pc_value | output | 32 | Value to load into PC |
| core_fetch_valid | input | 1 | Fetched word is valid |
| core_fetch_word | input | 32 | Fetched instruction word |
| core_retire | input | 1 | An instruction finished its last state |
| irq | output | 1 | Completion interrupt, level |

## Verification
The halt-word decode and the expiry of a cycle budget can land in the same cycle. The bench provokes this by presenting the halt word in exactly the last budgeted cycle. The result is judged by `core_run` dropping once, `irq` rising, and the cycle count equalling the budget, neither one short nor one over. A second case issues a host command in the same cycle as the halt word and checks that `irq` survives the clear that the command would otherwise cause.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int unsigned XLEN = 32;
    localparam logic [31:0] HALT_WORD = 32'h4080_0000;

    localparam logic [2:0] TGT_IMEM_WR = 3'd0;
    localparam logic [2:0] TGT_DMEM_WR = 3'd1;
    localparam logic [2:0] TGT_COPROC  = 3'd2;
    localparam logic [2:0] TGT_IMEM_RD = 3'd3;
    localparam logic [2:0] TGT_DMEM_RD = 3'd4;

    localparam logic [31:0] CP_CMD    = 32'd0;
    localparam logic [31:0] CP_ARG    = 32'd1;
    localparam logic [31:0] CP_BUDGET = 32'd2;

    localparam logic [31:0] OP_STOP    = 32'd0;
    localparam logic [31:0] OP_START   = 32'd1;
    localparam logic [31:0] OP_LOAD_PC = 32'd2;
    localparam logic [31:0] OP_START_T = 32'd3;
    localparam logic [31:0] OP_RD_CYC  = 32'd4;
    localparam logic [31:0] OP_RD_INS  = 32'd5;

    localparam logic [3:0] RSP_MEM = 4'h1;
    localparam logic [3:0] RSP_CNT = 4'h2;
    localparam logic [3:0] RSP_ERR = 4'hE;

    typedef enum logic [3:0] {
        ACT_NONE, ACT_MEM_WR, ACT_MEM_RD, ACT_ARG_WR, ACT_BUD_WR, ACT_LOAD_PC,
        ACT_START, ACT_START_T, ACT_STOP, ACT_RD_CYC, ACT_RD_INS, ACT_ERR
    } act_e;
endpackage

// File: rtl/rc_cmd_decode.sv
module rc_cmd_decode #(
    parameter int unsigned AW = 10
) (
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_target,
    input  logic [31:0]   cmd_addr,
    input  logic [31:0]   cmd_data,
    input  logic          running,
    input  logic          budget_zero,
    output rc_pkg::act_e  act,
    output logic          is_dmem
);
    import rc_pkg::*;

    logic in_range;
    assign in_range = (cmd_addr[1:0] == 2'b00) && ((cmd_addr >> (AW + 2)) == 32'd0);

    always_comb begin
        act     = ACT_NONE;
        is_dmem = 1'b0;
        if (cmd_valid) begin
            case (cmd_target)
                TGT_IMEM_WR, TGT_DMEM_WR: begin
                    is_dmem = (cmd_target == TGT_DMEM_WR);
                    act     = (in_range && !running) ? ACT_MEM_WR : ACT_ERR;
                end
                TGT_IMEM_RD, TGT_DMEM_RD: begin
                    is_dmem = (cmd_target == TGT_DMEM_RD);
                    act     = (in_range && !running) ? ACT_MEM_RD : ACT_ERR;
                end
                TGT_COPROC: begin
                    case (cmd_addr)
                        CP_ARG:    act = running ? ACT_ERR : ACT_ARG_WR;
                        CP_BUDGET: act = running ? ACT_ERR : ACT_BUD_WR;
                        CP_CMD: begin
                            case (cmd_data)
                                OP_STOP:    act = ACT_STOP;
                                OP_START:   act = running ? ACT_ERR : ACT_START;
                                OP_LOAD_PC: act = running ? ACT_ERR : ACT_LOAD_PC;
                                OP_START_T: act = (running || budget_zero) ? ACT_ERR : ACT_START_T;
                                OP_RD_CYC:  act = ACT_RD_CYC;
                                OP_RD_INS:  act = ACT_RD_INS;
                                default:    act = ACT_ERR;
                            endcase
                        end
                        default: act = ACT_ERR;
                    endcase
                end
                default: act = ACT_ERR;
            endcase
        end
    end
endmodule

// File: rtl/rc_run_ctrl.sv
module rc_run_ctrl #(
    parameter int unsigned BW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_timed,
    input  logic          stop_cmd,
    input  logic          cmd_seen,
    input  logic [BW-1:0] budget,
    input  logic          fetch_valid,
    input  logic [31:0]   fetch_word,
    output logic          running,
    output logic          irq
);
    import rc_pkg::*;

    typedef struct packed {
        logic          run;
        logic          timed;
        logic [BW-1:0] left;
        logic          irq;
    } run_st_t;

    run_st_t st_q, st_d;
    logic halt_hit, expire;

    always_comb begin
        st_d     = st_q;
        halt_hit = st_q.run && fetch_valid && (fetch_word == HALT_WORD);
        expire   = st_q.run && st_q.timed && (st_q.left == BW'(1));
        if (cmd_seen) st_d.irq = 1'b0;
        if (st_q.run && st_q.timed) st_d.left = st_q.left - BW'(1);
        if (start) begin
            st_d.run   = 1'b1;
            st_d.timed = 1'b0;
        end
        if (start_timed) begin
            st_d.run   = 1'b1;
            st_d.timed = 1'b1;
            st_d.left  = budget;
        end
        if (halt_hit || expire) begin
            st_d.run   = 1'b0;
            st_d.timed = 1'b0;
            st_d.irq   = 1'b1;
        end
        if (stop_cmd) begin
            st_d.run   = 1'b0;
            st_d.timed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.run;
    assign irq     = st_q.irq;

    a_r6_halt_word_stops: assert property (@(posedge clk) disable iff (!rst_n)
        running && fetch_valid && (fetch_word == HALT_WORD) |=> !running && irq);
    a_r7_budget_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run && st_q.timed |-> st_q.left != '0);
    a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !running);
    a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !cmd_seen |=> irq);
endmodule

// File: rtl/rc_perf_counters.sv
module rc_perf_counters #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          running,
    input  logic          retire,
    output logic [CW-1:0] cycles,
    output logic [CW-1:0] instrs
);
    typedef struct packed {
        logic [CW-1:0] cyc;
        logic [CW-1:0] ins;
    } cnt_st_t;

    cnt_st_t cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (running)           cnt_d.cyc = cnt_q.cyc + CW'(1);
        if (running && retire) cnt_d.ins = cnt_q.ins + CW'(1);
        if (clear)             cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cycles = cnt_q.cyc;
    assign instrs = cnt_q.ins;

    a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cycles == '0 && instrs == '0);
    a_r9_cycles_step: assert property (@(posedge clk) disable iff (!rst_n)
        running && !clear |=> cycles == CW'($past(cycles) + CW'(1)));
    a_r9_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !clear |=> $stable(cycles) && $stable(instrs));
endmodule

// File: rtl/rc_run_coproc.sv
module rc_run_coproc #(
    parameter int unsigned AW = 10,
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_target,
    input  logic [31:0]   cmd_addr,
    input  logic [31:0]   cmd_data,
    output logic          rsp_valid,
    output logic [3:0]    rsp_type,
    output logic [31:0]   rsp_addr,
    output logic [31:0]   rsp_data,
    output logic          hm_en,
    output logic          hm_we,
    output logic          hm_dmem,
    output logic [AW-1:0] hm_word,
    output logic [31:0]   hm_wdata,
    input  logic [31:0]   hm_rdata,
    output logic          core_run,
    output logic          core_pc_load,
    output logic [31:0]   core_pc_value,
    input  logic          core_fetch_valid,
    input  logic [31:0]   core_fetch_word,
    input  logic          core_retire,
    output logic          irq
);
    import rc_pkg::*;

    localparam int unsigned WLSB = 2;
    localparam int unsigned WMSB = AW + WLSB - 1;

    typedef struct packed {
        logic [XLEN-1:0] arg;
        logic [XLEN-1:0] budget;
        logic            rv;
        logic [3:0]      rt;
        logic [31:0]     ra;
        logic [XLEN-1:0] rd;
    } top_st_t;

    top_st_t st_q, st_d;
    act_e    act;
    logic    is_dmem;
    logic    running;
    logic [CW-1:0] cycles, instrs;

    rc_cmd_decode #(.AW(AW)) u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_target (cmd_target),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .running    (running),
        .budget_zero(st_q.budget == '0),
        .act        (act),
        .is_dmem    (is_dmem)
    );

    rc_run_ctrl #(.BW(XLEN)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (act == ACT_START),
        .start_timed(act == ACT_START_T),
        .stop_cmd   (act == ACT_STOP),
        .cmd_seen   (cmd_valid),
        .budget     (st_q.budget),
        .fetch_valid(core_fetch_valid),
        .fetch_word (core_fetch_word),
        .running    (running),
        .irq        (irq)
    );

    rc_perf_counters #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  ((act == ACT_START) || (act == ACT_START_T)),
        .running(running),
        .retire (core_retire),
        .cycles (cycles),
        .instrs (instrs)
    );

    always_comb begin
        st_d    = st_q;
        st_d.rv = 1'b0;
        st_d.ra = cmd_addr;
        case (act)
            ACT_ARG_WR: st_d.arg    = cmd_data;
            ACT_BUD_WR: st_d.budget = cmd_data;
            ACT_MEM_RD: begin st_d.rv = 1'b1; st_d.rt = RSP_MEM; st_d.rd = hm_rdata;       end
            ACT_RD_CYC: begin st_d.rv = 1'b1; st_d.rt = RSP_CNT; st_d.rd = XLEN'(cycles); end
            ACT_RD_INS: begin st_d.rv = 1'b1; st_d.rt = RSP_CNT; st_d.rd = XLEN'(instrs); end
            ACT_ERR:    begin st_d.rv = 1'b1; st_d.rt = RSP_ERR; st_d.rd = '0;            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hm_en         = (act == ACT_MEM_WR) || (act == ACT_MEM_RD);
    assign hm_we         = (act == ACT_MEM_WR);
    assign hm_dmem       = is_dmem;
    assign hm_word       = cmd_addr[WMSB:WLSB];
    assign hm_wdata      = cmd_data;
    assign core_run      = running;
    assign core_pc_load  = (act == ACT_LOAD_PC);
    assign core_pc_value = st_q.arg;
    assign rsp_valid     = st_q.rv;
    assign rsp_type      = st_q.rt;
    assign rsp_addr      = st_q.ra;
    assign rsp_data      = st_q.rd;

    a_r12_no_mem_while_running: assert property (@(posedge clk) disable iff (!rst_n)
        core_run && cmd_valid && (cmd_target != TGT_COPROC) |-> !hm_en);
    a_r3_misaligned_refused: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_target != TGT_COPROC) && (cmd_addr[1:0] != 2'b00)
        |=> rsp_valid && rsp_type == RSP_ERR);
    a_r2_rsp_echoes_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_addr == $past(cmd_addr));
endmodule

// File: tb/rc_run_coproc_test.sv
`timescale 1ns/1ps
module rc_run_coproc_test;
    localparam int AW = 10;
    localparam logic [31:0] HALT = 32'h4080_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_target = '0;
    logic [31:0] cmd_addr = '0, cmd_data = '0;
    logic rsp_valid, hm_en, hm_we, hm_dmem, core_run, core_pc_load, irq;
    logic [3:0] rsp_type;
    logic [31:0] rsp_addr, rsp_data, hm_wdata, hm_rdata, core_pc_value;
    logic [AW-1:0] hm_word;
    logic core_fetch_valid = 1'b0, core_retire = 1'b0;
    logic [31:0] core_fetch_word = '0;

    logic [31:0] imem [0:(1<<AW)-1];
    logic [31:0] dmem [0:(1<<AW)-1];

    int checks = 0, fails = 0;
    logic c_en, c_we, c_dm, c_pcl;
    logic [AW-1:0] c_word;
    logic [31:0] c_pcv;

    always #4 clk = ~clk;

    rc_run_coproc #(.AW(AW), .CW(32)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_target(cmd_target),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
        .rsp_type(rsp_type), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .hm_en(hm_en), .hm_we(hm_we), .hm_dmem(hm_dmem), .hm_word(hm_word),
        .hm_wdata(hm_wdata), .hm_rdata(hm_rdata), .core_run(core_run),
        .core_pc_load(core_pc_load), .core_pc_value(core_pc_value),
        .core_fetch_valid(core_fetch_valid), .core_fetch_word(core_fetch_word),
        .core_retire(core_retire), .irq(irq)
    );

    assign hm_rdata = hm_dmem ? dmem[hm_word] : imem[hm_word];
    always @(posedge clk) if (hm_en && hm_we) begin
        if (hm_dmem) dmem[hm_word] <= hm_wdata;
        else         imem[hm_word] <= hm_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] t, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_target = t; cmd_addr = a; cmd_data = d;
        #1;
        c_en = hm_en; c_we = hm_we; c_dm = hm_dmem; c_word = hm_word;
        c_pcl = core_pc_load; c_pcv = core_pc_value;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic halt_now();
        @(negedge clk);
        core_fetch_valid = 1'b1; core_fetch_word = HALT;
        @(posedge clk); #1;
        core_fetch_valid = 1'b0; core_fetch_word = '0;
    endtask

    task automatic t_reset();
        chk("R5 reset core_run", {31'd0, core_run}, 32'd0);
        chk("R5 reset irq", {31'd0, irq}, 32'd0);
        chk("R5 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_memory();
        issue(3'd0, 32'h8, 32'hCAFE_0001);
        chk("R1 imem write strobe", {29'd0, c_en, c_we, c_dm}, 32'b110);
        chk("R1 imem word index", 32'(c_word), 32'd2);
        chk("R1 no response on write", {31'd0, rsp_valid}, 32'd0);
        issue(3'd1, 32'h10, 32'hBEEF_0002);
        chk("R1 dmem write strobe", {29'd0, c_en, c_we, c_dm}, 32'b111);
        issue(3'd3, 32'h8, 32'h0);
        chk("R2 imem read type", {27'd0, rsp_valid, rsp_type}, 32'h11);
        chk("R2 imem read data", rsp_data, 32'hCAFE_0001);
        chk("R2 imem read addr", rsp_addr, 32'h8);
        issue(3'd4, 32'h10, 32'h0);
        chk("R2 dmem read data", rsp_data, 32'hBEEF_0002);
    endtask

    task automatic t_bad_addr();
        issue(3'd0, 32'h6, 32'h1234);
        chk("R3 misaligned no access", {31'd0, c_en}, 32'd0);
        chk("R3 misaligned error", {27'd0, rsp_valid, rsp_type}, 32'h1E);
        issue(3'd4, 32'h1000, 32'h0);
        chk("R3 out of range error", {27'd0, rsp_valid, rsp_type}, 32'h1E);
    endtask

    task automatic t_pc_load();
        issue(3'd2, 32'd1, 32'h40);
        issue(3'd2, 32'd0, 32'd2);
        chk("R4 pc load strobe", {31'd0, c_pcl}, 32'd1);
        chk("R4 pc load value", c_pcv, 32'h40);
    endtask

    task automatic t_run_halt();
        issue(3'd2, 32'd0, 32'd1);
        chk("R5 running after start", {31'd0, core_run}, 32'd1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            core_retire = (i % 2 == 0);
        end
        @(negedge clk); core_retire = 1'b0;
        halt_now();
        chk("R6 halt word stops core", {31'd0, core_run}, 32'd0);
        chk("R6 halt word raises irq", {31'd0, irq}, 32'd1);
        repeat (3) @(posedge clk);
        #1 chk("R11 irq held while idle", {31'd0, irq}, 32'd1);
        issue(3'd2, 32'd0, 32'd4);
        chk("R9 cycle count", rsp_data, 32'd8);
        chk("R9 counter type", 32'(rsp_type), 32'h2);
        chk("R11 irq cleared by command", {31'd0, irq}, 32'd0);
        issue(3'd2, 32'd0, 32'd5);
        chk("R9 instruction count", rsp_data, 32'd3);
        issue(3'd2, 32'd0, 32'd1);
        issue(3'd2, 32'd0, 32'd0);
        chk("R8 stop halts", {31'd0, core_run}, 32'd0);
        chk("R8 stop no irq", {31'd0, irq}, 32'd0);
        issue(3'd2, 32'd0, 32'd4);
        chk("R10 counter cleared on start", rsp_data, 32'd1);
    endtask

    task automatic t_refuse();
        issue(3'd2, 32'd0, 32'd1);
        issue(3'd0, 32'h20, 32'h5555);
        chk("R12 mem write blocked", {31'd0, c_en}, 32'd0);
        chk("R12 mem write refused", {27'd0, rsp_valid, rsp_type}, 32'h1E);
        issue(3'd2, 32'd1, 32'h99);
        chk("R12 arg write refused", 32'(rsp_type), 32'hE);
        issue(3'd2, 32'd0, 32'd4);
        chk("R12 counter read allowed", {27'd0, rsp_valid, rsp_type}, 32'h12);
        chk("R12 counter value while running", rsp_data, 32'd2);
        issue(3'd2, 32'd0, 32'd1);
        chk("R12 restart refused", 32'(rsp_type), 32'hE);
        issue(3'd2, 32'd0, 32'd0);
        issue(3'd2, 32'd0, 32'd2);
        chk("R12 arg unchanged", c_pcv, 32'h40);
        issue(3'd3, 32'h20, 32'h0);
        chk("R12 memory unchanged", rsp_data, 32'hx);
    endtask

    task automatic t_timed();
        issue(3'd2, 32'd2, 32'd4);
        issue(3'd2, 32'd0, 32'd3);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk("R7 running inside budget", {31'd0, core_run}, 32'd1);
        end
        @(posedge clk); #1;
        chk("R7 stops at budget", {31'd0, core_run}, 32'd0);
        chk("R7 budget irq", {31'd0, irq}, 32'd1);
        issue(3'd2, 32'd0, 32'd4);
        chk("R7 cycles equal budget", rsp_data, 32'd4);
        issue(3'd2, 32'd2, 32'd0);
        issue(3'd2, 32'd0, 32'd3);
        chk("R7 zero budget refused", 32'(rsp_type), 32'hE);
        chk("R7 zero budget no run", {31'd0, core_run}, 32'd0);
    endtask

    task automatic t_coincide();
        issue(3'd2, 32'd2, 32'd5);
        issue(3'd2, 32'd0, 32'd3);
        repeat (4) @(negedge clk);
        halt_now();
        chk("R6 R7 coincident halt", {30'd0, core_run, irq}, 32'b01);
        issue(3'd2, 32'd0, 32'd4);
        chk("R7 coincident cycle count", rsp_data, 32'd5);
        issue(3'd2, 32'd2, 32'd10);
        issue(3'd2, 32'd0, 32'd3);
        repeat (2) @(negedge clk);
        halt_now();
        issue(3'd2, 32'd0, 32'd4);
        chk("R6 halt cuts budget short", rsp_data, 32'd3);
        issue(3'd2, 32'd0, 32'd1);
        @(negedge clk);
        core_fetch_valid = 1'b1; core_fetch_word = HALT;
        cmd_valid = 1'b1; cmd_target = 3'd2; cmd_addr = 32'd0; cmd_data = 32'd5;
        @(posedge clk); #1;
        core_fetch_valid = 1'b0; cmd_valid = 1'b0;
        chk("R11 event beats clearing command", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_bad_cmd();
        issue(3'd5, 32'd0, 32'd0);
        chk("R13 unknown target", {27'd0, rsp_valid, rsp_type}, 32'h1E);
        issue(3'd2, 32'd0, 32'd9);
        chk("R13 unknown code", 32'(rsp_type), 32'hE);
        issue(3'd2, 32'd7, 32'd0);
        chk("R13 unknown coproc address", 32'(rsp_type), 32'hE);
    endtask

    logic done = 1'b0;
    initial begin
        for (int i = 0; i < (1 << AW); i++) begin imem[i] = '0; dmem[i] = '0; end
        imem[8] = 32'hx;
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_memory();
        t_bad_addr();
        t_pc_load();
        t_run_halt();
        t_refuse();
        t_timed();
        t_coincide();
        t_bad_cmd();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule